// File: doc/BRIEF.md
# Cartridge Program-ROM Bank Controller

This block sits between the CPU bus of an 8-bit console and the program ROM of a cartridge. It watches CPU writes to the upper half of the address space and keeps three kinds of state: a single bank register, a mode register, and three 8 KB window registers. For every CPU address it forms a ROM byte address. The register writes select one of two mappings, either two 16 KB windows or four 8 KB windows of which the last is fixed. The low two bits of the mode register also drive the nametable mirroring select.

A small expansion area sits below the ROM window. One address there returns the floating data bus with its two low bits forced to zero. Four addresses hold general read/write scratch bytes. The ROM array itself, the picture side and any interrupt timer sit outside this block. The ROM size is a parameter. Every address the block produces wraps to that size.

Top module: `cart_prg_bank`

## Requirements
- R1: A write to 0x8000, 0xB000, 0xB0FF or 0xB1FF loads the bank register with the data byte and sets mode bit 6, which selects 16 KB mapping; the change is visible from the next clock.
- R2: A write to 0x8100 replaces mode bits 7 and 5:0 with the data byte while mode bit 6 keeps its value.
- R3: A write to 0x8300, 0x8301 or 0x8302 loads 8 KB window register 0, 1 or 2 and clears mode bit 6 (8 KB mapping).
- R4: In 16 KB mapping, an address in 0x8000–0xBFFF maps to bank[5:0] × 16384 plus address bits 13:0.
- R5: In 16 KB mapping, an address in 0xC000–0xFFFF maps to ((bank AND 0x30) OR 0x0F) × 16384 plus address bits 13:0.
- R6: In 8 KB mapping, address bits 14:13 pick a window; windows 0–2 map to their register × 8192 plus address bits 12:0, and window 3 maps to the last 8 KB bank (ROM_KB/8 − 1).
- R7: The ROM byte address is taken modulo the ROM size, and rom_sel is high exactly for addresses 0x8000–0xFFFF.
- R8: mirror equals mode[1:0] (0 vertical, 1 horizontal, 2 single-screen A, 3 single-screen B) and follows a mode write from the next clock.
- R9: An address of 0x5000 gives exp_hit = 1 and exp_rdata = bus_float with bits 1:0 cleared.
- R10: Addresses 0x5100–0x5103 are four read/write scratch bytes selected by address bits 1:0 (exp_hit = 1); every other address outside 0x5000 gives exp_hit = 0 and exp_rdata = 0.
- R11: A synchronous reset clears the bank, mode, window and scratch registers, which gives 8 KB mapping and vertical mirroring.
- R12: A write to any other address, for example 0x8001 or 0x8303, changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address, used for both writes and reads |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_float | input | 8 | Floating data-bus value for the 0x5000 read |
| rom_addr | output | ROM_AW | ROM byte address for cpu_addr |
| rom_sel | output | 1 | cpu_addr is within the ROM window |
| mirror | output | 2 | Nametable mirroring select |
| exp_rdata | output | 8 | Expansion-area read data |
| exp_hit | output | 1 | cpu_addr decodes to an expansion-area location |

## Verification
The bench builds the block with ROM_KB = 128, which gives a 17-bit ROM address. Under that setting, bank values of 0x10 and above and window values of 0x10 and above fold back into the ROM, so the wrap rule is exercised. The fixed upper 16 KB window ((bank AND 0x30) OR 0x0F) also lands on a truncated index, and the fixed last 8 KB window is bank 15. A behavioural model follows every write. On each clock it is compared with the mapping, mirroring and expansion outputs while pseudo-random addresses sweep the whole ROM window.

// File: rtl/cart_prg_pkg.sv
package cart_prg_pkg;

    localparam int NUM_WIN    = 3;
    localparam int MODE16_BIT = 6;
    localparam int SCRATCH_N  = 4;
    localparam int SCR_AW     = $clog2(SCRATCH_N);
    localparam int FULL_AW    = 22;

    localparam logic [15:0] ADDR_MODE     = 16'h8100;
    localparam logic [13:0] WIN_BASE_HI   = 14'h20C0;
    localparam logic [15:0] ADDR_OPENBUS  = 16'h5000;
    localparam logic [13:0] SCR_BASE_HI   = 14'h1440;

    typedef enum logic [1:0] {
        MIR_VERT  = 2'd0,
        MIR_HORZ  = 2'd1,
        MIR_ONE_A = 2'd2,
        MIR_ONE_B = 2'd3
    } mirror_e;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_BANK,
        WR_MODE,
        WR_WIN
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e    kind;
        logic [1:0]  win;
    } wr_dec_t;

    typedef struct packed {
        logic [7:0]                bank;
        logic [7:0]                mode;
        logic [NUM_WIN-1:0][7:0]   win;
    } prg_state_t;

    function automatic wr_dec_t decode_wr(input logic [15:0] a);
        wr_dec_t d;
        d.kind = WR_NONE;
        d.win  = 2'd0;
        if (a == 16'h8000 || a == 16'hB000 || a == 16'hB0FF || a == 16'hB1FF) begin
            d.kind = WR_BANK;
        end else if (a == ADDR_MODE) begin
            d.kind = WR_MODE;
        end else if (a[15:2] == WIN_BASE_HI && int'(a[1:0]) < NUM_WIN) begin
            d.kind = WR_WIN;
            d.win  = a[1:0];
        end
        return d;
    endfunction

    function automatic mirror_e mirror_of(input logic [7:0] mode);
        return mirror_e'(mode[1:0]);
    endfunction

    function automatic logic [7:0] upper16_idx(input logic [7:0] bank);
        return (bank & 8'h30) | 8'h0F;
    endfunction

    function automatic logic [7:0] lower16_idx(input logic [7:0] bank);
        return {2'b00, bank[5:0]};
    endfunction

endpackage

// File: rtl/cart_prg_regs.sv
module cart_prg_regs
    import cart_prg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_we,
    output prg_state_t  st
);

    wr_dec_t    dec;
    logic [7:0] bank_q;
    logic [7:0] mode_q;
    logic [7:0] win_q [NUM_WIN];

    always_comb dec = decode_wr(cpu_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (cpu_we && dec.kind == WR_BANK) begin
            bank_q <= cpu_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (cpu_we) begin
            unique case (dec.kind)
                WR_BANK: mode_q[MODE16_BIT] <= 1'b1;
                WR_MODE: begin
                    mode_q[7]   <= cpu_wdata[7];
                    mode_q[5:0] <= cpu_wdata[5:0];
                end
                WR_WIN:  mode_q[MODE16_BIT] <= 1'b0;
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                win_q[i] <= '0;
            end else if (cpu_we && dec.kind == WR_WIN && dec.win == 2'(i)) begin
                win_q[i] <= cpu_wdata;
            end
        end
        assign st.win[i] = win_q[i];
    end

    assign st.bank = bank_q;
    assign st.mode = mode_q;

    assert_bank_mode_R1: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && (cpu_addr == 16'h8000 || cpu_addr == 16'hB000 ||
                    cpu_addr == 16'hB0FF || cpu_addr == 16'hB1FF))
        |=> (mode_q[MODE16_BIT] && bank_q == $past(cpu_wdata)));

    assert_mode_keep_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr == 16'h8100)
        |=> (mode_q[MODE16_BIT] == $past(mode_q[MODE16_BIT]) &&
             mode_q[5:0] == $past(cpu_wdata[5:0]) &&
             mode_q[7] == $past(cpu_wdata[7])));

    assert_win_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && (cpu_addr == 16'h8300 || cpu_addr == 16'h8301 || cpu_addr == 16'h8302))
        |=> !mode_q[MODE16_BIT]);

    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (mode_q == 8'h00 && bank_q == 8'h00));

    assert_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && (cpu_addr == 16'h8001 || cpu_addr == 16'h8303))
        |=> ($stable(mode_q) && $stable(bank_q)));

endmodule

// File: rtl/cart_prg_map.sv
module cart_prg_map
    import cart_prg_pkg::*;
#(
    parameter int ROM_KB = 256,
    parameter int ROM_AW = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  prg_state_t        st,
    input  logic [15:0]       cpu_addr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_sel
);

    localparam logic [7:0] LAST8 = 8'((ROM_KB / 8) - 1);
    localparam int         HI8_W = ROM_AW - 13;

    logic               mode16;
    logic [1:0]         wsel;
    logic [7:0]         idx16;
    logic [7:0]         idx8;
    logic [FULL_AW-1:0] full;

    assign mode16 = st.mode[MODE16_BIT];
    assign wsel   = cpu_addr[14:13];

    always_comb begin
        idx16 = cpu_addr[14] ? upper16_idx(st.bank) : lower16_idx(st.bank);
        idx8  = LAST8;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (wsel == 2'(i)) idx8 = st.win[i];
        end
        if (mode16) begin
            full = {idx16, cpu_addr[13:0]};
        end else begin
            full = {1'b0, idx8, cpu_addr[12:0]};
        end
    end

    assign rom_addr = full[ROM_AW-1:0];
    assign rom_sel  = cpu_addr[15];

    assert_low_pass16_R4: assert property (@(posedge clk) disable iff (rst)
        (mode16 && cpu_addr[15]) |-> rom_addr[13:0] == cpu_addr[13:0]);

    assert_last_win_R6: assert property (@(posedge clk) disable iff (rst)
        (!mode16 && cpu_addr[15:13] == 3'b111)
        |-> (rom_addr[12:0] == cpu_addr[12:0] &&
             rom_addr[ROM_AW-1:13] == HI8_W'((ROM_KB / 8) - 1)));

    assert_sel_window_R7: assert property (@(posedge clk) disable iff (rst)
        rom_sel == (cpu_addr >= 16'h8000));

endmodule

// File: rtl/cart_exp_regs.sv
module cart_exp_regs
    import cart_prg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_we,
    input  logic [7:0]  bus_float,
    output logic [7:0]  exp_rdata,
    output logic        exp_hit
);

    logic             scr_hit;
    logic             ob_hit;
    logic [SCR_AW-1:0] sidx;
    logic [7:0]       scr_q [SCRATCH_N];
    logic [7:0]       scr_rd;

    assign scr_hit = (cpu_addr[15:SCR_AW] == SCR_BASE_HI);
    assign ob_hit  = (cpu_addr == ADDR_OPENBUS);
    assign sidx    = cpu_addr[SCR_AW-1:0];

    for (genvar i = 0; i < SCRATCH_N; i++) begin : g_scr
        always_ff @(posedge clk) begin
            if (rst) begin
                scr_q[i] <= '0;
            end else if (cpu_we && scr_hit && sidx == SCR_AW'(i)) begin
                scr_q[i] <= cpu_wdata;
            end
        end
    end

    always_comb begin
        scr_rd = '0;
        for (int i = 0; i < SCRATCH_N; i++) begin
            if (sidx == SCR_AW'(i)) scr_rd = scr_q[i];
        end
    end

    always_comb begin
        exp_rdata = 8'h00;
        if (ob_hit) begin
            exp_rdata = {bus_float[7:2], 2'b00};
        end else if (scr_hit) begin
            exp_rdata = scr_rd;
        end
    end

    assign exp_hit = ob_hit | scr_hit;

    assert_open_bus_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr == 16'h5000) |-> (exp_hit && exp_rdata[1:0] == 2'b00 &&
                                    exp_rdata[7:2] == bus_float[7:2]));

    assert_scratch_keep_R10: assert property (@(posedge clk) disable iff (rst)
        (!cpu_we && cpu_addr[15:2] == 14'h1440) ##1 (cpu_addr == $past(cpu_addr))
        |-> $stable(exp_rdata));

    assert_miss_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr != 16'h5000 && cpu_addr[15:2] != 14'h1440)
        |-> (!exp_hit && exp_rdata == 8'h00));

endmodule

// File: rtl/cart_prg_bank.sv
module cart_prg_bank
    import cart_prg_pkg::*;
#(
    parameter  int ROM_KB = 256,
    localparam int ROM_AW = $clog2(ROM_KB * 1024)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    input  logic [7:0]        bus_float,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_sel,
    output logic [1:0]        mirror,
    output logic [7:0]        exp_rdata,
    output logic              exp_hit
);

    prg_state_t st;
    mirror_e    mir;

    cart_prg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_we    (cpu_we),
        .st        (st)
    );

    cart_prg_map #(
        .ROM_KB (ROM_KB),
        .ROM_AW (ROM_AW)
    ) u_map (
        .clk      (clk),
        .rst      (rst),
        .st       (st),
        .cpu_addr (cpu_addr),
        .rom_addr (rom_addr),
        .rom_sel  (rom_sel)
    );

    cart_exp_regs u_exp (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_we    (cpu_we),
        .bus_float (bus_float),
        .exp_rdata (exp_rdata),
        .exp_hit   (exp_hit)
    );

    assign mir    = mirror_of(st.mode);
    assign mirror = mir;

    assert_mirror_follow_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr == 16'h8100) |=> mirror == $past(cpu_wdata[1:0]));

endmodule

// File: tb/sim_cart_prg_bank.sv
module sim_cart_prg_bank;

    localparam int CLK_PERIOD = 10;
    localparam int ROM_KB     = 128;
    localparam int ROM_BYTES  = ROM_KB * 1024;
    localparam int AW         = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   cpu_addr = 16'h0000;
    logic [7:0]    cpu_wdata = 8'h00;
    logic          cpu_we = 1'b0;
    logic [7:0]    bus_float = 8'h00;
    logic [AW-1:0] rom_addr;
    logic          rom_sel;
    logic [1:0]    mirror;
    logic [7:0]    exp_rdata;
    logic          exp_hit;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference state
    int m_bank = 0;
    int m_mode = 0;
    int m_win [3] = '{0, 0, 0};
    int m_scr [4] = '{0, 0, 0, 0};

    always #(CLK_PERIOD / 2) clk = ~clk;

    cart_prg_bank #(.ROM_KB(ROM_KB)) u0 (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_we    (cpu_we),
        .bus_float (bus_float),
        .rom_addr  (rom_addr),
        .rom_sel   (rom_sel),
        .mirror    (mirror),
        .exp_rdata (exp_rdata),
        .exp_hit   (exp_hit)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%0h expected=%0h", tag, cpu_addr, act, exp);
        end
    endtask

    // reference model update
    always @(posedge clk) begin
        if (rst) begin
            m_bank = 0; m_mode = 0;
            foreach (m_win[i]) m_win[i] = 0;
            foreach (m_scr[i]) m_scr[i] = 0;
        end else if (cpu_we) begin
            case (int'(cpu_addr))
                'h8000, 'hB000, 'hB0FF, 'hB1FF: begin
                    m_bank = int'(cpu_wdata);
                    m_mode = m_mode | 'h40;
                end
                'h8100: m_mode = (int'(cpu_wdata) & 'hBF) | (m_mode & 'h40);
                'h8300, 'h8301, 'h8302: begin
                    m_win[int'(cpu_addr) - 'h8300] = int'(cpu_wdata);
                    m_mode = m_mode & 'hBF;
                end
                'h5100, 'h5101, 'h5102, 'h5103:
                    m_scr[int'(cpu_addr) - 'h5100] = int'(cpu_wdata);
                default: ;
            endcase
        end
    end

    function automatic int exp_rom(input int a);
        int idx;
        if ((m_mode & 'h40) != 0) begin
            idx = (a < 'hC000) ? (m_bank & 'h3F) : ((m_bank & 'h30) | 'h0F);
            return (idx * 16384 + (a & 'h3FFF)) % ROM_BYTES;
        end
        idx = (a >> 13) & 3;
        idx = (idx == 3) ? (ROM_KB / 8 - 1) : m_win[idx];
        return (idx * 8192 + (a & 'h1FFF)) % ROM_BYTES;
    endfunction

    function automatic string rom_tag(input int a);
        if ((m_mode & 'h40) != 0) return (a < 'hC000) ? "R4" : "R5";
        return "R6";
    endfunction

    task automatic check_all();
        int a;
        a = int'(cpu_addr);
        chk("R7 sel", int'(rom_sel), int'(a >= 'h8000));
        if (a >= 'h8000) chk(rom_tag(a), int'(rom_addr), exp_rom(a));
        chk("R8 mirror", int'(mirror), m_mode & 3);
        if (a == 'h5000) begin
            chk("R9 hit", int'(exp_hit), 1);
            chk("R9 data", int'(exp_rdata), int'(bus_float) & 'hFC);
        end else if (a >= 'h5100 && a <= 'h5103) begin
            chk("R10 hit", int'(exp_hit), 1);
            chk("R10 data", int'(exp_rdata), m_scr[a & 3]);
        end else begin
            chk("R10 miss", int'(exp_hit), 0);
            chk("R10 miss data", int'(exp_rdata), 0);
        end
    endtask

    // compare against the model on every clock
    always @(posedge clk) begin
        #(CLK_PERIOD / 4);
        if (!rst && !done) check_all();
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd(input int a);
        @(negedge clk);
        cpu_addr = 16'(a);
        #(CLK_PERIOD / 4);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state -> 8 KB mapping, vertical mirroring
        rd('hE123);
        chk("R11 last bank", int'(rom_addr), 15 * 8192 + 'h0123);
        chk("R11 mirror", int'(mirror), 0);
        rd('h8456);
        chk("R11 win0", int'(rom_addr), 'h0456);
        rd('h5101);
        chk("R11 scratch", int'(exp_rdata), 0);

        // R3 / R6 / R7: window registers, including folding values
        wr('h8300, 'h05);
        wr('h8301, 'h1F);
        wr('h8302, 'h0A);
        rd('h8010); chk("R3 win0", int'(rom_addr), 5 * 8192 + 'h10);
        rd('hA020); chk("R7 win1 wrap", int'(rom_addr), ('h1F * 8192 + 'h20) % ROM_BYTES);
        rd('hC030); chk("R6 win2", int'(rom_addr), 'h0A * 8192 + 'h30);
        rd('hFFFF); chk("R6 last", int'(rom_addr), ROM_BYTES - 1);

        // R2 / R8: mode write keeps bit 6 clear
        wr('h8100, 'h43);
        rd('h8010); chk("R2 still 8k", int'(rom_addr), 5 * 8192 + 'h10);
        chk("R8 one-screen B", int'(mirror), 3);

        // R1 / R4 / R5: bank writes through each alias
        wr('hB0FF, 'h3A);
        rd('h8123); chk("R4 lower", int'(rom_addr), ('h3A * 16384 + 'h123) % ROM_BYTES);
        rd('hC123); chk("R5 upper", int'(rom_addr), ('h3F * 16384 + 'h123) % ROM_BYTES);
        wr('h8100, 'h01);
        rd('h8123); chk("R2 keeps 16k", int'(rom_addr), ('h3A * 16384 + 'h123) % ROM_BYTES);
        chk("R8 horizontal", int'(mirror), 1);
        wr('h8302, 'h02);
        rd('h8123); chk("R3 back to 8k", int'(rom_addr), 5 * 8192 + 'h123);
        wr('hB000, 'h04);
        rd('hBFFF); chk("R1 alias B000", int'(rom_addr), 4 * 16384 + 'h3FFF);
        rd('hC000); chk("R5 fixed upper", int'(rom_addr), ('h0F * 16384) % ROM_BYTES);
        wr('h8301, 'h00);
        wr('hB1FF, 'h06);
        rd('h8000); chk("R1 alias B1FF", int'(rom_addr), 6 * 16384);
        wr('h8300, 'h00);
        wr('h8000, 'h07);
        rd('h8001); chk("R1 alias 8000", int'(rom_addr), 7 * 16384 + 1);
        wr('h8100, 'h02);
        rd('h8001); chk("R8 single A", int'(mirror), 2);

        // R12: other addresses change nothing
        wr('h8001, 'hFF);
        wr('h8303, 'hFF);
        wr('hB0FE, 'h11);
        rd('h8001); chk("R12 bank kept", int'(rom_addr), 7 * 16384 + 1);
        chk("R12 mirror kept", int'(mirror), 2);

        // R9 / R10: expansion area
        @(negedge clk); bus_float = 8'hFF;
        rd('h5000); chk("R9 open bus", int'(exp_rdata), 'hFC);
        @(negedge clk); bus_float = 8'h5B;
        rd('h5000); chk("R9 open bus 2", int'(exp_rdata), 'h58);
        for (int i = 0; i < 4; i++) wr('h5100 + i, 'h30 + i * 7);
        for (int i = 0; i < 4; i++) begin
            rd('h5100 + i);
            chk("R10 scratch", int'(exp_rdata), 'h30 + i * 7);
        end
        rd('h5104); chk("R10 outside", int'(exp_hit), 0);
        rd('h4FFF); chk("R10 below", int'(exp_hit), 0);

        // sweep with pseudo-random addresses under both mappings
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (k == 100) wr('h8301, int'(lfsr[7:0]));
            if (k == 200) wr('hB000, int'(lfsr[7:0]));
            rd(int'({1'b1, lfsr[14:0]}));
        end

        // R11: reset again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd('hE000); chk("R11 re-reset", int'(rom_addr), 15 * 8192);
        chk("R11 re-reset mirror", int'(mirror), 0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule